// File: doc/BRIEF.md
# Strided Line Copy Engine

This block is the address and flow engine of a raw copy unit. It moves data from a source buffer to a destination buffer in 16-byte chunks, without changing the data. Each side walks its own buffer line by line. A line is a set number of chunks, and after each line the address skips a set number of gap chunks. Because the source and the destination each have their own line shape, a sub-rectangle can be taken from one buffer and placed into another buffer of a different pitch.

Software programs a few registers: source base, destination base, total byte count, and one dimension word for each side. It then sets the trigger bit. The engine issues read chunk addresses on a source stream and write chunk addresses with data on a destination stream. A small chunk FIFO between the two streams lets each side stall on its own. The copy ends once the payload byte total has been moved; gap chunks never count toward that total. Parameter sets that would lock up a real copy unit are rejected at once. Such a set raises an error status and completes without any transfer.

Register offsets on `reg_addr`:
- 0: source byte base
- 1: destination byte base
- 2: byte size
- 3: input dimension word
- 4: output dimension word
- 5: control/status

While the engine is busy, all register writes are ignored.

Top module: `strided_copy_engine`

## Requirements
- R1: After reset, the control/status word reads 0, `irq` is low, and neither `src_valid` nor `dst_valid` is asserted.
- R2: A control write whose bit 0 is 1 and whose parameters are valid sets the busy bit (status bit 0) from the next cycle. It also clears the done and error bits and stores the crop flag (write bit 2, read back at bit 2).
- R3: Read chunk addresses start at source base bits [31:4]. Payload chunk k reads from base + (k / W)·(W + G) + (k mod W), where the input dimension word holds W in bits 15:0 and G in bits 31:16. When G is 0, the address is base + k.
- R4: Write chunk addresses follow the same rule, using destination base bits [31:4] and the output dimension word.
- R5: Chunks are written in the order they were read, and each chunk's 128-bit data is unchanged.
- R6: Each side moves exactly ceil(size/16) chunks. A size that is not a multiple of 16 rounds up, and skipped gap chunks do not count.
- R7: After the last write is accepted, busy clears and done (status bit 8) sets. `irq` pulses high for exactly one cycle per completed run.
- R8: With both gaps zero (contiguous mode), a size below 16 is invalid.
- R9: With any gap nonzero (gap mode), a size below 192, or a line width of zero on either side, is invalid.
- R10: In gap mode, a start without the crop flag set is invalid.
- R11: An invalid start sets done and error (status bit 9) and pulses `irq`. It leaves busy clear and makes no read or write requests.
- R12: The FIFO never holds more than DEPTH chunks. When the write side stalls, reads stop once DEPTH chunks are buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | One-cycle completion pulse |
| src_valid | output | 1 | Read chunk request |
| src_ready | input | 1 | Source accepts request; data valid in same cycle |
| src_addr | output | 28 | Read chunk address |
| src_data | input | 128 | Chunk data returned on handshake |
| dst_valid | output | 1 | Write chunk request |
| dst_ready | input | 1 | Destination accepts write |
| dst_addr | output | 28 | Write chunk address |
| dst_data | output | 128 | Write chunk data |

## Verification
A control write lands on one clock edge. The status change, or the error with its `irq` pulse, is therefore visible from the next cycle. The bench reads status at the falling edge after that write. The first read request can appear in the cycle after a valid start. A chunk can be written one cycle after it was read. Completion flags and `irq` follow the edge that accepts the last write. For this reason, the bench records every handshake and counts `irq` at falling edges, judging the address and data sequences only once busy has cleared. The stall test holds the write side off for many cycles and then counts accepted reads against DEPTH.

// File: rtl/strided_copy_engine.sv
module strided_copy_engine #(
  parameter int AW    = 28,
  parameter int DW    = 128,
  parameter int DEPTH = 4,
  parameter int CW    = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          src_valid,
  input  logic          src_ready,
  output logic [AW-1:0] src_addr,
  input  logic [DW-1:0] src_data,
  output logic          dst_valid,
  input  logic          dst_ready,
  output logic [AW-1:0] dst_addr,
  output logic [DW-1:0] dst_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [31:0] src_base, dst_base, size_b, in_dim, out_dim;
  logic        crop, busy, done, err;
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [15:0]   rd_col, wr_col;
  logic [CW-1:0] rd_left, wr_left;
  logic [DW-1:0] fifo [DEPTH];
  logic [PW-1:0] head, tail;
  logic [PW:0]   count;

  wire [15:0] in_w  = in_dim[15:0];
  wire [15:0] in_g  = in_dim[31:16];
  wire [15:0] out_w = out_dim[15:0];
  wire [15:0] out_g = out_dim[31:16];
  wire [32:0] size_up  = {1'b0, size_b} + 33'd15;
  wire [CW-1:0] nchunks = size_up[32:4];
  wire gap_mode = (in_g != 16'd0) || (out_g != 16'd0);
  wire bad = gap_mode ? (size_b < 32'd192 || in_w == 16'd0 || out_w == 16'd0 || !reg_wdata[2])
                      : (size_b < 32'd16);
  wire ctrl_wr = reg_wr && (reg_addr == 3'd5) && !busy;

  assign src_valid = busy && (rd_left != '0) && (count < (PW+1)'(DEPTH));
  assign dst_valid = busy && (count != '0);
  assign src_addr  = rd_ptr;
  assign dst_addr  = wr_ptr;
  assign dst_data  = fifo[head];

  wire rd_hs = src_valid && src_ready;
  wire wr_hs = dst_valid && dst_ready;
  wire rd_eol = (rd_col == in_w - 16'd1);
  wire wr_eol = (wr_col == out_w - 16'd1);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = src_base;
      3'd1:    reg_rdata = dst_base;
      3'd2:    reg_rdata = size_b;
      3'd3:    reg_rdata = in_dim;
      3'd4:    reg_rdata = out_dim;
      3'd5:    reg_rdata = {22'd0, err, done, 5'd0, crop, 1'b0, busy};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base <= '0; dst_base <= '0; size_b <= '0; in_dim <= '0; out_dim <= '0;
      crop <= 1'b0; busy <= 1'b0; done <= 1'b0; err <= 1'b0; irq <= 1'b0;
      rd_ptr <= '0; wr_ptr <= '0; rd_col <= '0; wr_col <= '0;
      rd_left <= '0; wr_left <= '0;
    end else begin
      irq <= 1'b0;
      if (reg_wr && !busy) begin
        case (reg_addr)
          3'd0: src_base <= reg_wdata;
          3'd1: dst_base <= reg_wdata;
          3'd2: size_b   <= reg_wdata;
          3'd3: in_dim   <= reg_wdata;
          3'd4: out_dim  <= reg_wdata;
          default: ;
        endcase
      end
      if (ctrl_wr) begin
        crop <= reg_wdata[2];
        done <= 1'b0;
        err  <= 1'b0;
        if (reg_wdata[0]) begin
          if (bad) begin
            done <= 1'b1;
            err  <= 1'b1;
            irq  <= 1'b1;
          end else begin
            busy    <= 1'b1;
            rd_ptr  <= src_base[AW+3:4];
            wr_ptr  <= dst_base[AW+3:4];
            rd_col  <= '0;
            wr_col  <= '0;
            rd_left <= nchunks;
            wr_left <= nchunks;
          end
        end
      end
      if (rd_hs) begin
        rd_left <= rd_left - 1'b1;
        rd_col  <= rd_eol ? 16'd0 : rd_col + 16'd1;
        rd_ptr  <= rd_ptr + (rd_eol ? AW'(in_g) + AW'(1) : AW'(1));
      end
      if (wr_hs) begin
        wr_left <= wr_left - 1'b1;
        wr_col  <= wr_eol ? 16'd0 : wr_col + 16'd1;
        wr_ptr  <= wr_ptr + (wr_eol ? AW'(out_g) + AW'(1) : AW'(1));
        if (wr_left == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          irq  <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0; tail <= '0; count <= '0;
    end else begin
      if (rd_hs) tail <= (tail == PW'(DEPTH-1)) ? '0 : tail + 1'b1;
      if (wr_hs) head <= (head == PW'(DEPTH-1)) ? '0 : head + 1'b1;
      count <= count + (PW+1)'(rd_hs) - (PW+1)'(wr_hs);
    end
  end

  always_ff @(posedge clk) if (rd_hs) fifo[tail] <= src_data;

  assert_fifo_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (PW+1)'(DEPTH));
  assert_balance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_left == rd_left + CW'(count));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!src_valid && !dst_valid));
  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_busy_fall_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && irq && !err));
  assert_src_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !src_ready) |=> (src_valid && $stable(src_addr)));
  assert_dst_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_addr) && $stable(dst_data)));
endmodule

// File: tb/tb_strided_copy_engine.sv
module tb_strided_copy_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic irq, src_valid, src_ready = 1'b0, dst_valid, dst_ready = 1'b0;
  logic [27:0] src_addr, dst_addr;
  logic [127:0] src_data, dst_data;

  always #5 clk = ~clk;

  strided_copy_engine dut (.*);

  assign src_data = {4{4'hA, src_addr}};

  int checks = 0, errors = 0, cyc = 0;
  int nrd = 0, nwr = 0, nirq = 0;
  bit stall = 1'b0;
  logic [27:0]  rd_log [64];
  logic [27:0]  wr_log [64];
  logic [127:0] wd_log [64];

  always @(negedge clk) begin
    cyc++;
    if (irq) nirq++;
    src_ready = (cyc % 4) != 1;
    dst_ready = !stall && ((cyc % 3) != 0);
    if (src_valid && src_ready) begin
      if (nrd < 64) rd_log[nrd] = src_addr;
      nrd++;
    end
    if (dst_valid && dst_ready) begin
      if (nwr < 64) begin wr_log[nwr] = dst_addr; wd_log[nwr] = dst_data; end
      nwr++;
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd5;
  endtask

  function automatic logic [27:0] exp_addr(input logic [27:0] base, input int k, input int w, input int g);
    if (w == 0) return base + 28'(k);
    return base + 28'((k / w) * (w + g) + (k % w));
  endfunction

  localparam int NV = 9;
  localparam int V_SIZE [NV] = '{64, 40, 192, 256, 15, 176, 192, 192, 16};
  localparam int V_IW   [NV] = '{0,  0,  2,   4,   0,  2,   0,   2,   0};
  localparam int V_IG   [NV] = '{0,  0,  1,   4,   0,  1,   1,   1,   0};
  localparam int V_OW   [NV] = '{0,  0,  3,   16,  0,  2,   2,   2,   0};
  localparam int V_OG   [NV] = '{0,  0,  2,   0,   0,  0,   0,   1,   0};
  localparam int V_CROP [NV] = '{0,  0,  1,   1,   0,  1,   1,   0,   0};
  localparam int V_ERR  [NV] = '{0,  0,  0,   0,   1,  1,   1,   1,   0};
  localparam logic [31:0] SBASE = 32'h0001_0000;
  localparam logic [31:0] DBASE = 32'h0008_0040;

  task automatic wait_idle();
    int t = 0;
    @(negedge clk);
    while (reg_rdata[0] && t < 5000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  initial begin
    reg_addr = 3'd5;
    repeat (3) @(negedge clk);
    chk(reg_rdata == 32'd0 && !irq && !src_valid && !dst_valid, "R1 reset state",
        {reg_rdata, irq, src_valid, dst_valid}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    wreg(3'd0, SBASE);
    wreg(3'd1, DBASE);

    for (int v = 0; v < NV; v++) begin
      int n, bad_rd, bad_wr, bad_dat;
      string tag;
      n = (V_SIZE[v] + 15) / 16;
      wreg(3'd2, 32'(V_SIZE[v]));
      wreg(3'd3, {16'(V_IG[v]), 16'(V_IW[v])});
      wreg(3'd4, {16'(V_OG[v]), 16'(V_OW[v])});
      nrd = 0; nwr = 0; nirq = 0;
      wreg(3'd5, 32'h1 | (V_CROP[v] != 0 ? 32'h4 : 32'h0));
      if (V_ERR[v] != 0) begin
        tag = (V_SIZE[v] < 16) ? "R8 short contiguous" :
              (V_CROP[v] == 0) ? "R10 gap without crop" : "R9 gap size/width";
        chk(reg_rdata[9:8] == 2'b11 && !reg_rdata[0], tag, reg_rdata, 32'h304);
        repeat (6) @(negedge clk);
        chk(nrd == 0 && nwr == 0 && nirq == 1 && reg_rdata[9:8] == 2'b11, "R11 error no traffic",
            {nrd[15:0], nwr[15:0], nirq[15:0]}, {16'd0, 16'd0, 16'd1});
      end else begin
        chk(reg_rdata[0] && reg_rdata[9:8] == 2'b00 && reg_rdata[2] == (V_CROP[v] != 0), "R2 busy after start",
            reg_rdata, 32'h1);
        wait_idle();
        bad_rd = 0; bad_wr = 0; bad_dat = 0;
        for (int k = 0; k < n && k < 64; k++) begin
          logic [27:0] er, ew;
          er = exp_addr(SBASE[31:4], k, V_IW[v], V_IG[v]);
          ew = exp_addr(DBASE[31:4], k, V_OW[v], V_OG[v]);
          if (rd_log[k] !== er) begin bad_rd++; $display("FAIL R3 vec %0d chunk %0d: actual %0h expected %0h", v, k, rd_log[k], er); end
          if (wr_log[k] !== ew) begin bad_wr++; $display("FAIL R4 vec %0d chunk %0d: actual %0h expected %0h", v, k, wr_log[k], ew); end
          if (wd_log[k] !== {4{4'hA, er}}) begin bad_dat++; $display("FAIL R5 vec %0d chunk %0d: actual %0h expected %0h", v, k, wd_log[k], {4{4'hA, er}}); end
        end
        chk(bad_rd == 0, "R3 read addresses", bad_rd, 0);
        chk(bad_wr == 0, "R4 write addresses", bad_wr, 0);
        chk(bad_dat == 0, "R5 data order", bad_dat, 0);
        chk(nrd == n && nwr == n, "R6 chunk count", {nrd[31:0], nwr[31:0]}, {n[31:0], n[31:0]});
        chk(reg_rdata[9:8] == 2'b01 && !reg_rdata[0] && nirq == 1, "R7 completion",
            {reg_rdata, nirq[7:0]}, {32'h100, 8'd1});
      end
    end

    // R12: write side stalled
    stall = 1'b1;
    wreg(3'd2, 32'd128);
    wreg(3'd3, 32'd0);
    wreg(3'd4, 32'd0);
    nrd = 0; nwr = 0; nirq = 0;
    wreg(3'd5, 32'h1);
    repeat (30) @(negedge clk);
    chk(nrd == 4 && nwr == 0 && reg_rdata[0], "R12 fifo bound under stall",
        {nrd[15:0], nwr[15:0]}, {16'd4, 16'd0});
    stall = 1'b0;
    wait_idle();
    chk(nrd == 8 && nwr == 8 && nirq == 1, "R12 drain after stall",
        {nrd[15:0], nwr[15:0], nirq[15:0]}, {16'd8, 16'd8, 16'd1});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule